// File: doc/BRIEF.md
# Newton-Raphson Reciprocal Divider

This block divides an unsigned fractional dividend by a normalized fractional divisor. It does not use digit recurrence. First it forms a coarse estimate of the divisor's reciprocal with a linear expression. It then sharpens that estimate with a parameterized number of Newton-Raphson passes. Each pass computes a correction term `2 − D·X` and then the new estimate `X·(2 − D·X)`. Because convergence is quadratic, every pass roughly doubles the number of correct bits. Last, the block multiplies the reciprocal by the dividend.

One multiplier and one subtractor carry every operation. A small controller sequences them, one operation per clock cycle. Internal values use two integer bits and a parameterized number of fraction bits, and every product is truncated.

A caller drives the operands and pulses `start_i` while the block is idle. The caller then waits for the single-cycle `done_o` and reads `quotient_o`, which keeps its value until the next division completes.

Top module: `nr_divider`

## Requirements
- R1: After reset, `done_o` is 0 and `quotient_o` is 0.
- R2: `start_i` is accepted only while the block is idle. `dividend_i` and `divisor_i` are captured at the edge that accepts `start_i`. Later changes to these inputs do not affect the running division.
- R3: `done_o` is high for exactly one cycle. It rises 3·ITERS+2 clock edges after the edge that accepted `start_i`, which is 8 edges for ITERS=2.
- R4: The seed reciprocal is X0 = 2.9142 − 2·D. The constant 2.9142 is held with FRAC_W fraction bits. For D in [0.5, 1), this seed lies in [0.9, 2).
- R5: Each refinement pass takes three cycles. The first computes the product D·X, the second computes 2 minus that product, and the third multiplies the estimate by that difference. Only one datapath operation is performed per cycle.
- R6: `divisor_i` carries D = divisor_i/2^16 and must be at least 0x8000. `dividend_i` carries A = dividend_i/2^16. `quotient_o` carries Q = quotient_o/2^15, which is unsigned Q1.15. Q saturates at 0xFFFF.
- R7: With ITERS=2, `quotient_o` lies within ±2 of floor(dividend_i·2^15 / divisor_i) for every legal divisor and every dividend.
- R8: At the boundary divisors 0x8000 (D = 0.5) and 0xFFFF (just below 1), the result stays within the tolerance of R7 across the full dividend range.
- R9: A dividend of 0 yields a quotient of exactly 0.
- R10: `quotient_o` changes only in the cycle in which `done_o` is high. It holds its value until the next completion.
- R11: A `start_i` pulse while a division is running is ignored. Neither the result nor the completion time of the running division changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start request, sampled while idle |
| dividend_i | input | 16 | Dividend fraction A·2^16 |
| divisor_i | input | 16 | Divisor fraction D·2^16, at least 0x8000 |
| quotient_o | output | 16 | Quotient, unsigned Q1.15, truncated |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
The bench builds the block with its defaults: two refinement passes and twenty internal fraction bits. With these values one division takes nine cycles, so the run can cover every fourth legal divisor code, each paired with a varying dividend. It also sweeps the dividend finely at both boundary divisors. This brings the worst-case seed error near D = 1, together with the accumulated truncation after two passes, within reach of the ±2 tolerance check. The same configuration lets the bench check the exact completion latency, ignored mid-run start pulses and the holding of the result.

// File: rtl/nr_div_pkg.sv
package nr_div_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SEED,
    ST_MUL_DX,
    ST_SUB,
    ST_MUL_X,
    ST_MUL_A,
    ST_DONE
  } nr_state_e;

  typedef enum logic [1:0] {
    MSEL_DX,
    MSEL_XT,
    MSEL_AX
  } mul_sel_e;

  typedef enum logic {
    SSEL_SEED,
    SSEL_CORR
  } sub_sel_e;

endpackage

// File: rtl/nr_div_mul.sv
module nr_div_mul #(
  parameter int W      = 22,
  parameter int FRAC_W = 20
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_i,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] p_o
);

  localparam int PW = 2 * W;

  logic [PW-1:0] prod;
  logic [PW-1:0] prod_sh;
  logic          ovf;

  always_comb begin
    prod    = {{W{1'b0}}, a_i} * {{W{1'b0}}, b_i};
    prod_sh = prod >> FRAC_W;
    p_o     = prod_sh[W-1:0];
    ovf     = |prod_sh[PW-1:W];
  end

  // truncated product must fit the Q2.FRAC_W range
  AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni) en_i |-> !ovf); // R6

endmodule

// File: rtl/nr_div_sub.sv
module nr_div_sub #(
  parameter int W      = 22,
  parameter int FRAC_W = 20
) (
  input  nr_div_pkg::sub_sel_e sel_i,
  input  logic [W-1:0]         d_i,
  input  logic [W-1:0]         t_i,
  output logic [W-1:0]         r_o
);
  import nr_div_pkg::*;

  localparam logic [W-1:0] SEED_K = W'((64'd29142 << FRAC_W) / 64'd10000);
  localparam logic [W-1:0] TWO_Q  = W'(64'd2 << FRAC_W);

  logic [W-1:0] lhs;
  logic [W-1:0] rhs;

  always_comb begin
    if (sel_i == SSEL_SEED) begin
      lhs = SEED_K;
      rhs = d_i << 1;
    end else begin
      lhs = TWO_Q;
      rhs = t_i;
    end
    r_o = lhs - rhs;
  end

endmodule

// File: rtl/nr_div_ctrl.sv
module nr_div_ctrl #(
  parameter int ITERS = 2
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 start_i,
  output logic                 idle_o,
  output logic                 latch_o,
  output logic                 seed_we_o,
  output logic                 t_mul_we_o,
  output logic                 t_sub_we_o,
  output logic                 x_mul_we_o,
  output logic                 q_we_o,
  output nr_div_pkg::mul_sel_e mul_sel_o,
  output nr_div_pkg::sub_sel_e sub_sel_o,
  output logic                 done_o
);
  import nr_div_pkg::*;

  localparam int CNT_W = (ITERS > 1) ? $clog2(ITERS) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(ITERS - 1);

  nr_state_e        state_q, state_d;
  logic [CNT_W-1:0] iter_q, iter_d;

  always_comb begin
    state_d    = state_q;
    iter_d     = iter_q;
    latch_o    = 1'b0;
    seed_we_o  = 1'b0;
    t_mul_we_o = 1'b0;
    t_sub_we_o = 1'b0;
    x_mul_we_o = 1'b0;
    q_we_o     = 1'b0;
    done_o     = 1'b0;
    mul_sel_o  = MSEL_DX;
    sub_sel_o  = SSEL_CORR;
    unique case (state_q)
      ST_IDLE: begin
        if (start_i) begin
          latch_o = 1'b1;
          state_d = ST_SEED;
        end
      end
      ST_SEED: begin
        seed_we_o = 1'b1;
        sub_sel_o = SSEL_SEED;
        iter_d    = '0;
        state_d   = ST_MUL_DX;
      end
      ST_MUL_DX: begin
        t_mul_we_o = 1'b1;
        mul_sel_o  = MSEL_DX;
        state_d    = ST_SUB;
      end
      ST_SUB: begin
        t_sub_we_o = 1'b1;
        sub_sel_o  = SSEL_CORR;
        state_d    = ST_MUL_X;
      end
      ST_MUL_X: begin
        x_mul_we_o = 1'b1;
        mul_sel_o  = MSEL_XT;
        if (iter_q == LAST) begin
          state_d = ST_MUL_A;
        end else begin
          iter_d  = iter_q + 1'b1;
          state_d = ST_MUL_DX;
        end
      end
      ST_MUL_A: begin
        q_we_o    = 1'b1;
        mul_sel_o = MSEL_AX;
        state_d   = ST_DONE;
      end
      ST_DONE: begin
        done_o  = 1'b1;
        state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      iter_q  <= '0;
    end else begin
      state_q <= state_d;
      iter_q  <= iter_d;
    end
  end

  assign idle_o = (state_q == ST_IDLE);

  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni) done_o |=> !done_o); // R3
  AST_ONE_OP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({seed_we_o, t_mul_we_o, t_sub_we_o, x_mul_we_o, q_we_o})); // R5
  AST_ITER_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni) iter_q <= LAST); // R5
  AST_SUB_AFTER_MUL: assert property (@(posedge clk_i) disable iff (!rst_ni) t_mul_we_o |=> t_sub_we_o); // R5

endmodule

// File: rtl/nr_divider.sv
module nr_divider #(
  parameter int IN_W   = 16,
  parameter int OUT_W  = 16,
  parameter int FRAC_W = 20,
  parameter int ITERS  = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [IN_W-1:0]  dividend_i,
  input  logic [IN_W-1:0]  divisor_i,
  output logic [OUT_W-1:0] quotient_o,
  output logic             done_o
);
  import nr_div_pkg::*;

  localparam int W         = FRAC_W + 2;
  localparam int SHIFT_IN  = FRAC_W - IN_W;
  localparam int SHIFT_OUT = FRAC_W - (OUT_W - 1);
  localparam logic [W-1:0] TWO_Q    = W'(64'd2 << FRAC_W);
  localparam logic [W-1:0] X0_MIN   = W'((64'd9 << FRAC_W) / 64'd10);
  localparam logic [W-1:0] T_LOW    = W'(64'd3 << (FRAC_W - 2));
  localparam logic [W-1:0] T_HIGH   = W'(64'd5 << (FRAC_W - 2));

  logic [IN_W-1:0]  a_q, d_q;
  logic [W-1:0]     x_q, t_q;
  logic [OUT_W-1:0] q_q;
  logic [W-1:0]     a_ext, d_ext;
  logic [W-1:0]     mul_a, mul_b, mul_res, sub_res, q_sh;

  logic     idle, latch, seed_we, t_mul_we, t_sub_we, x_mul_we, q_we;
  mul_sel_e mul_sel;
  sub_sel_e sub_sel;

  nr_div_ctrl #(.ITERS(ITERS)) u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start_i),
    .idle_o     (idle),
    .latch_o    (latch),
    .seed_we_o  (seed_we),
    .t_mul_we_o (t_mul_we),
    .t_sub_we_o (t_sub_we),
    .x_mul_we_o (x_mul_we),
    .q_we_o     (q_we),
    .mul_sel_o  (mul_sel),
    .sub_sel_o  (sub_sel),
    .done_o     (done_o)
  );

  assign a_ext = {{(W-IN_W){1'b0}}, a_q} << SHIFT_IN;
  assign d_ext = {{(W-IN_W){1'b0}}, d_q} << SHIFT_IN;

  always_comb begin
    unique case (mul_sel)
      MSEL_XT: begin mul_a = x_q;   mul_b = t_q; end
      MSEL_AX: begin mul_a = a_ext; mul_b = x_q; end
      default: begin mul_a = d_ext; mul_b = x_q; end
    endcase
  end

  nr_div_mul #(.W(W), .FRAC_W(FRAC_W)) u_mul (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (t_mul_we | x_mul_we | q_we),
    .a_i    (mul_a),
    .b_i    (mul_b),
    .p_o    (mul_res)
  );

  nr_div_sub #(.W(W), .FRAC_W(FRAC_W)) u_sub (
    .sel_i (sub_sel),
    .d_i   (d_ext),
    .t_i   (t_q),
    .r_o   (sub_res)
  );

  assign q_sh = mul_res >> SHIFT_OUT;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      a_q <= '0;
      d_q <= '0;
      x_q <= '0;
      t_q <= '0;
      q_q <= '0;
    end else begin
      if (latch) begin
        a_q <= dividend_i;
        d_q <= divisor_i;
      end
      if (seed_we)       x_q <= sub_res;
      else if (x_mul_we) x_q <= mul_res;
      if (t_mul_we)      t_q <= mul_res;
      else if (t_sub_we) t_q <= sub_res;
      if (q_we)          q_q <= (|q_sh[W-1:OUT_W]) ? '1 : q_sh[OUT_W-1:0];
    end
  end

  assign quotient_o = q_q;

  AST_OPERANDS_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !idle |=> ($stable(a_q) && $stable(d_q))); // R11
  AST_SEED_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seed_we |=> (x_q >= X0_MIN && x_q < TWO_Q)); // R4
  AST_RECIP_BELOW_TWO: assert property (@(posedge clk_i) disable iff (!rst_ni) x_q < TWO_Q); // R4
  AST_CORR_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    t_sub_we |=> (t_q > T_LOW && t_q < T_HIGH)); // R5
  AST_QUOT_ONLY_AT_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(quotient_o) |-> done_o); // R10

endmodule

// File: tb/sim_nr_divider.sv
module sim_nr_divider;

  localparam int  ITERS = 2;
  localparam int  LAT   = 3 * ITERS + 2;
  localparam time TCK   = 8ns;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [15:0] dvd = '0;
  logic [15:0] dvs = 16'h8000;
  logic [15:0] quot;
  logic        done;

  int n_tests = 0;
  int n_fail  = 0;

  always #(TCK/2) clk = ~clk;

  nr_divider #(.ITERS(ITERS)) u0 (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .start_i    (start),
    .dividend_i (dvd),
    .divisor_i  (dvs),
    .quotient_o (quot),
    .done_o     (done)
  );

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
  endtask

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // issue one division; returns quotient and latency; optional busy start pulse
  task automatic run_div(input logic [15:0] a, input logic [15:0] d, input int poke_at,
                         output logic [15:0] q, output int lat);
    @(negedge clk);
    dvd   = a;
    dvs   = d;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    lat   = 0;
    while (lat < 40) begin
      if (lat == poke_at) begin
        dvd   = ~a;
        dvs   = 16'h8000 | (d ^ 16'h1234);
        start = 1'b1;
      end
      @(negedge clk);
      start = 1'b0;
      lat++;
      if (done) break;
    end
    q = quot;
  endtask

  task automatic chk_quot(input logic [15:0] a, input logic [15:0] d, input logic [15:0] q,
                          input string req);
    longint ex, df;
    ex = (longint'(a) << 15) / longint'(d);
    if (ex > 65535) ex = 65535;
    df = ex - longint'(q);
    chk(df >= -2 && df <= 2, req, q, ex);
  endtask

  initial begin
    #(TCK * 190000);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    logic [15:0] q, q1;
    int          lat;

    #(TCK * 3);
    // R1: reset state
    chk(done == 1'b0, "R1 done", done, 0);
    chk(quot == 16'h0, "R1 quotient", quot, 0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(done == 1'b0 && quot == 16'h0, "R1 after release", quot, 0);

    // R3: latency and pulse width
    run_div(16'h5000, 16'hE000, -1, q, lat);
    chk(lat == LAT, "R3 latency", lat, LAT);
    chk_quot(16'h5000, 16'hE000, q, "R7 basic");
    @(negedge clk);
    chk(done == 1'b0, "R3 single-cycle done", done, 0);

    // R10: result holds
    for (int i = 0; i < 5; i++) begin
      dvd = 16'(i * 999);
      @(negedge clk);
    end
    chk(quot == q, "R10 hold", quot, q);

    // R9: zero dividend
    run_div(16'h0000, 16'hA5A5, -1, q, lat);
    chk(q == 16'h0, "R9 zero dividend", q, 0);

    // R11: start pulse while busy is ignored
    run_div(16'hC000, 16'hF000, -1, q1, lat);
    run_div(16'hC000, 16'hF000, 3, q, lat);
    chk(lat == LAT, "R11 latency unchanged", lat, LAT);
    chk(q == q1, "R11 result unchanged", q, q1);
    @(negedge clk);
    chk(done == 1'b0, "R11 no second completion", done, 0);

    // R2: operand change after acceptance
    run_div(16'h7777, 16'h9000, 1, q, lat);
    chk_quot(16'h7777, 16'h9000, q, "R2 captured operands");

    // R8: boundary divisors across dividend range
    for (int i = 0; i < 256; i++) begin
      logic [15:0] a;
      a = 16'(i * 257);
      run_div(a, 16'h8000, -1, q, lat);
      chk_quot(a, 16'h8000, q, "R8 D=0.5");
      run_div(a, 16'hFFFF, -1, q, lat);
      chk_quot(a, 16'hFFFF, q, "R8 D~1");
    end
    run_div(16'hFFFF, 16'h8000, -1, q, lat);
    chk_quot(16'hFFFF, 16'h8000, q, "R6 max quotient");

    // R7: sweep of divisors with varying dividends
    for (int d = 32768; d < 65536; d += 4) begin
      logic [15:0] a;
      a = 16'((d * 40503 + (d >> 3)) ^ 16'h5A5A);
      run_div(a, 16'(d), -1, q, lat);
      chk_quot(a, 16'(d), q, "R7 sweep");
      if ((d & 16'h0FFC) == 0) chk(lat == LAT, "R3 latency sweep", lat, LAT);
    end

    summary();
    $finish;
  end

endmodule